// File: doc/BRIEF.md
# Host Bridge Control Register File

A bank of 28 word-wide control and status registers that sits behind a simple 32-bit read/write port on a host bridge. Most entries are plain storage words: the software writes them and reads them back. An interrupt unit nearby reads three of them directly as ports: the live interrupt enable word, the edge-select word and the polarity word. The register file also takes in that unit's pending-interrupt vector and shows it as a read-only status word.

The interrupt enable word is read-only. Software changes it only through two alias words. A write to the first alias turns enable bits on. A write to the second alias turns enable bits off. Both aliases also keep the last value written to them. Bit 2 of the general configuration word is a software reset trigger. A write that moves this bit from 0 to 1 sends out a one-cycle system reset request.

Every access is a full 32-bit word. The register index is the byte offset shifted right by two. Read data is registered and appears one cycle after the read is accepted.

Top module: `hbr_ctl_regs`

## Requirements
- R1: A write to any plain storage word (offsets 0x00–0x6C, excluding 0x38 and 0x3C) stores the full 32-bit value. A read of that offset returns the value on `rd_data` in the cycle after the clock edge that accepts the read. Address bits [1:0] are ignored.
- R2: After a synchronous active-low reset, offset 0x00 reads 0xC40, 0x04 reads 0x1384, 0x08 reads 0x2BFF8010, 0x0C reads 0x255E0091, 0x10 reads 0x6140, 0x1C reads 0x1FF, 0x20 reads 0x1FF, 0x68 reads 0x8 and 0x6C reads 0x10000000. Every other offset reads 0, and `sys_reset_req` is low.
- R3: A write to offset 0x30 stores the written value at 0x30 and ORs it into the enable word at 0x38.
- R4: A write to offset 0x34 stores the written value at 0x34 and clears every bit of the enable word at 0x38 where the written value has a 1.
- R5: Writes to offset 0x38 (enable) and offset 0x3C (status) change nothing.
- R6: Offset 0x3C returns `irq_pending` as it was sampled on the clock edge before the edge that accepts the read.
- R7: A write to offset 0x04 whose bit 2 is 1, when the stored bit 2 is 0, drives `sys_reset_req` high for exactly the one cycle after that write. The written value is stored all the same. A write that finds bit 2 already set gives no pulse.
- R8: Offsets 0x70–0x7C are not defined. Writes to them change nothing, and reads of them return 0.
- R9: `irq_enable` always equals the enable word (0x38), `irq_edge` equals the word at 0x24, and `irq_pol` equals the word at 0x2C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_pending | input | 32 | Pending-interrupt vector from the interrupt unit |
| irq_enable | output | 32 | Current interrupt enable word |
| irq_edge | output | 32 | Edge/level select word |
| irq_pol | output | 32 | Polarity word |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench checks the software reset trigger in three cases: writing the bit to 0, writing it to 1, and writing 1 again. A design that compared against the written value instead of the stored one would pulse on the repeated write. A design that dropped the stored value would read 0x1380 back. The enable aliases are tested with overlapping set and clear masks, followed by direct writes to the read-only enable and status words. A design that let those writes through would change `irq_enable`. The bench also writes and reads the undefined offsets above 0x6C and then reads the whole bank. This catches an index that wraps into a real register.

// File: rtl/hbr_pkg.sv
// Shared constants for the host bridge control register file.
// Assumes 32-bit words and word indices equal to byte offset >> 2.
package hbr_pkg;
    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 28;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int ADDR_W   = IDX_W + 2;

    // Word indices whose behaviour differs from plain storage
    localparam int IX_GCFG  = 1;
    localparam int IX_EDGE  = 9;
    localparam int IX_POL   = 11;
    localparam int IX_ENSET = 12;
    localparam int IX_ENCLR = 13;
    localparam int IX_EN    = 14;
    localparam int IX_ISR   = 15;
    localparam int RST_BIT  = 2;

    // Reset value of each word index
    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        case (idx)
            0:       return 32'h0000_0C40;
            1:       return 32'h0000_1384;
            2:       return 32'h2BFF_8010;
            3:       return 32'h255E_0091;
            4:       return 32'h0000_6140;
            7:       return 32'h0000_01FF;
            8:       return 32'h0000_01FF;
            26:      return 32'h0000_0008;
            27:      return 32'h1000_0000;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/hbr_addr_dec.sv
// Address decoder: turns a byte offset into a word index and a hit flag.
// Assumes word accesses only; the two low address bits are dropped.
module hbr_addr_dec #(
    parameter int ADDR_W   = 7,
    parameter int NUM_REGS = 28,
    parameter int IDX_W    = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              hit
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;

    // Word index and range check
    always_comb begin
        word = addr[ADDR_W-1:2];
        idx  = IDX_W'(word);
        hit  = (int'(word) < NUM_REGS);
    end
endmodule

// File: rtl/hbr_ien_unit.sv
// Interrupt enable word. It changes only through set/clear alias writes.
// Assumes at most one of set_wr / clr_wr is high in a cycle.
module hbr_ien_unit #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wr,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ien
);
    // Enable word update
    always_ff @(posedge clk) begin
        if (!rst_n)      ien <= '0;
        else if (set_wr) ien <= ien | wdata;
        else if (clr_wr) ien <= ien & ~wdata;
    end

    // R3
    property p_set;
        @(posedge clk) disable iff (!rst_n)
        set_wr |=> ((ien & $past(wdata)) == $past(wdata));
    endproperty
    ien_set_chk: assert property (p_set);

    // R4
    property p_clr;
        @(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((ien & $past(wdata)) == '0);
    endproperty
    ien_clr_chk: assert property (p_clr);

    // R5
    property p_hold;
        @(posedge clk) disable iff (!rst_n)
        (!set_wr && !clr_wr) |=> $stable(ien);
    endproperty
    ien_hold_chk: assert property (p_hold);
endmodule

// File: rtl/hbr_rstreq_gen.sv
// Reset request generator: pulses on a software 0->1 move of the trigger bit.
// Assumes cur_bit is the stored trigger bit before the write lands.
module hbr_rstreq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cur_bit,
    input  logic new_bit,
    output logic req
);
    // Registered one-cycle request
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= cfg_wr & ~cur_bit & new_bit;
    end

    // R7
    property p_pulse;
        @(posedge clk) disable iff (!rst_n)
        req |=> !req;
    endproperty
    rst_pulse_chk: assert property (p_pulse);
endmodule

// File: rtl/hbr_ctl_regs.sv
// Host bridge control register file: 28 words, set/clear enable aliases,
// live status capture and a software reset trigger.
// Assumes one full-word access per cycle and synchronous active-low reset.
module hbr_ctl_regs
    import hbr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] rd_data,
    input  logic [DW-1:0] irq_pending,
    output logic [DW-1:0] irq_enable,
    output logic [DW-1:0] irq_edge,
    output logic [DW-1:0] irq_pol,
    output logic          sys_reset_req
);
    logic [IDX_W-1:0] idx;
    logic             hit;
    logic             wr_ok;
    logic [DW-1:0]    bank [NUM_REGS];
    logic [DW-1:0]    ien;

    hbr_addr_dec #(.ADDR_W(AW), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
        .addr (bus_addr),
        .idx  (idx),
        .hit  (hit)
    );

    assign wr_ok = bus_sel & bus_we & hit;

    hbr_ien_unit #(.DATA_W(DW)) u_ien (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_wr (wr_ok && (int'(idx) == IX_ENSET)),
        .clr_wr (wr_ok && (int'(idx) == IX_ENCLR)),
        .wdata  (bus_wdata),
        .ien    (ien)
    );

    hbr_rstreq_gen u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (wr_ok && (int'(idx) == IX_GCFG)),
        .cur_bit (bank[IX_GCFG][RST_BIT]),
        .new_bit (bus_wdata[RST_BIT]),
        .req     (sys_reset_req)
    );

    // One storage element per word index; the variant depends on the index
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        if (i == IX_EN) begin : g_en
            assign bank[i] = ien;
        end else if (i == IX_ISR) begin : g_isr
            logic [DW-1:0] q;
            // Status word follows the pending vector each cycle
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= irq_pending;
            end
            assign bank[i] = q;
        end else begin : g_plain
            logic [DW-1:0] q;
            // Plain storage word with its own reset value
            always_ff @(posedge clk) begin
                if (!rst_n)                             q <= reset_value(i);
                else if (wr_ok && (int'(idx) == i))     q <= bus_wdata;
            end
            assign bank[i] = q;
        end
    end

    // Registered read port; undefined offsets read as zero
    always_ff @(posedge clk) begin
        if (!rst_n)                 rd_data <= '0;
        else if (bus_sel && !bus_we) rd_data <= hit ? bank[idx] : '0;
    end

    assign irq_enable = ien;
    assign irq_edge   = bank[IX_EDGE];
    assign irq_pol    = bank[IX_POL];

    // R8
    property p_undef_rd;
        @(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && !hit) |=> (rd_data == '0);
    endproperty
    undef_read_chk: assert property (p_undef_rd);

    // R6
    property p_isr;
        @(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && (int'(bus_addr[AW-1:2]) == IX_ISR))
            |=> (rd_data == $past(bank[IX_ISR]));
    endproperty
    isr_read_chk: assert property (p_isr);
endmodule

// File: tb/hbr_ctl_regs_test.sv
module hbr_ctl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic [31:0] irq_pending = '0;
    logic [31:0] irq_enable, irq_edge, irq_pol;
    logic        sys_reset_req;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hbr_ctl_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .irq_pending(irq_pending), .irq_enable(irq_enable),
        .irq_edge(irq_edge), .irq_pol(irq_pol), .sys_reset_req(sys_reset_req)
    );

    localparam int NV = 12;
    localparam logic [6:0]  V_ADDR [NV] = '{7'h00, 7'h08, 7'h0C, 7'h10, 7'h1C, 7'h24,
                                            7'h2C, 7'h40, 7'h4C, 7'h6C, 7'h70, 7'h7C};
    localparam logic [31:0] V_WR   [NV] = '{32'hDEADBEEF, 32'h12345678, 32'h0, 32'hFFFFFFFF,
                                            32'h155, 32'h0000F00F, 32'h0F0F0000, 32'hCAFEF00D,
                                            32'h80000001, 32'h13579BDF, 32'hFFFFFFFF, 32'h11111111};
    localparam logic [31:0] V_EXP  [NV] = '{32'hDEADBEEF, 32'h12345678, 32'h0, 32'hFFFFFFFF,
                                            32'h155, 32'h0000F00F, 32'h0F0F0000, 32'hCAFEF00D,
                                            32'h80000001, 32'h13579BDF, 32'h0, 32'h0};

    function automatic logic [31:0] exp_reset(input int off);
        case (off)
            'h00: return 32'hC40;
            'h04: return 32'h1384;
            'h08: return 32'h2BFF8010;
            'h0C: return 32'h255E0091;
            'h10: return 32'h6140;
            'h1C: return 32'h1FF;
            'h20: return 32'h1FF;
            'h68: return 32'h8;
            'h6C: return 32'h10000000;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset values of every word
        check("R2 reset_req", {31'b0, sys_reset_req}, 32'h0);
        for (int off = 0; off < 'h70; off += 4) begin
            rd(7'(off), v);
            check("R2", v, exp_reset(off));
        end
        // R1 / R8: table walk of write-then-read vectors
        for (int i = 0; i < NV; i++) begin
            wr(V_ADDR[i], V_WR[i]);
            rd(V_ADDR[i] | 7'h3, v);
            check((V_ADDR[i] >= 7'h70) ? "R8" : "R1", v, V_EXP[i]);
        end
        // R8: undefined writes left real words untouched
        rd(7'h00, v); check("R8 no alias", v, 32'hDEADBEEF);
        rd(7'h0C, v); check("R8 no alias", v, 32'h0);
        // R9: edge and polarity ports
        check("R9 edge", irq_edge, 32'h0000F00F);
        check("R9 pol", irq_pol, 32'h0F0F0000);
        // R3: set alias
        wr(7'h30, 32'h000000F0);
        check("R3 port", irq_enable, 32'h000000F0);
        wr(7'h30, 32'h0000000F);
        rd(7'h38, v); check("R3 en", v, 32'h000000FF);
        rd(7'h30, v); check("R3 stored", v, 32'h0000000F);
        // R4: clear alias
        wr(7'h34, 32'h0000003C);
        rd(7'h38, v); check("R4 en", v, 32'h000000C3);
        rd(7'h34, v); check("R4 stored", v, 32'h0000003C);
        check("R9 enable", irq_enable, 32'h000000C3);
        // R5: direct writes to enable and status ignored
        wr(7'h38, 32'hFFFFFFFF);
        check("R5 enable", irq_enable, 32'h000000C3);
        irq_pending = 32'h0000A5A5;
        wr(7'h3C, 32'h12345678);
        rd(7'h3C, v); check("R5/R6 status", v, 32'h0000A5A5);
        // R6: status follows pending
        irq_pending = 32'h80000003;
        @(negedge clk);
        rd(7'h3C, v); check("R6 status", v, 32'h80000003);
        // R7: software reset trigger
        wr(7'h04, 32'h1380);
        check("R7 no pulse clear", {31'b0, sys_reset_req}, 32'h0);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 7'h04; bus_wdata = 32'h1384;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        check("R7 pulse", {31'b0, sys_reset_req}, 32'h1);
        @(negedge clk);
        check("R7 pulse end", {31'b0, sys_reset_req}, 32'h0);
        rd(7'h04, v); check("R7 stored", v, 32'h1384);
        wr(7'h04, 32'h1384);
        check("R7 no repeat", {31'b0, sys_reset_req}, 32'h0);
        // R2: reset mid-run restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(7'h00, v); check("R2 rerst", v, 32'hC40);
        check("R2 rerst enable", irq_enable, 32'h0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule